// File: doc/BRIEF.md
# Serial port FIFO status controller

This block sits between the register side and the bit shifter of a synchronous serial port. It holds a transmit FIFO and a receive FIFO, eight words deep by default, and derives every FIFO status signal of the port from their fill levels. Software writes words for transmission and reads received words. The shifter pulls transmit words and pushes received words through single-cycle strobes.

Each direction has a level-based service request. The transmit request means the FIFO has room to be refilled. The receive request means the FIFO has enough words to be worth draining. Each request drives a DMA request line with no masking, and drives an interrupt line only when software has enabled it. A receive word that arrives while the receive FIFO is full is dropped. The drop latches an overrun flag, and the flag raises an interrupt that no enable can mask.

A 16-bit status word is read combinationally from `cpu_rdata`. The only writable field is the overrun flag, which is cleared by writing 1. When the port goes from enabled to disabled, both FIFOs are emptied.

Top module: `serport_fifo_stat`

## Requirements
- R1: The receive service request (`rx_dma_req`, status bit 5) is 1 exactly when the port is enabled and the receive FIFO holds 4 or more words. It is 0 at 3 or fewer words.
- R2: The transmit service request (`tx_dma_req`, status bit 4) is 1 exactly when the port is enabled and the transmit FIFO holds 4 or fewer words. It is 0 at 5 or more words and whenever `port_en` is 0.
- R3: Each DMA request follows its service request regardless of the mask inputs. `rx_irq` and `tx_irq` equal their service request ANDed with `rx_mask_en` and `tx_mask_en`.
- R4: A receive push while the receive FIFO holds 8 words, with no accepted pop in the same cycle, discards the word and sets the overrun flag (status bit 6). This happens for every such push.
- R5: `ovr_irq` is 1 whenever the overrun flag is set, whatever the mask inputs are.
- R6: The status word has bit 1 = transmit not full, bit 2 = receive not empty, bit 3 = busy, bit 4 = transmit request, bit 5 = receive request, bit 6 = overrun. Bit 0 and bits 15..7 read 0.
- R7: Busy (bit 3) equals `frame_active` while the port is enabled and reads 0 while it is disabled. It drives no interrupt output.
- R8: A register write with bit 6 = 1 clears the overrun flag. Bit 6 = 0 leaves the flag unchanged. Writes do not change any other status bit.
- R9: After reset, with the port disabled, the status reads 0x0002 and the overrun flag is 0.
- R10: In the first cycle after `port_en` goes from 1 to 0, both FIFOs are emptied.
- R11: A push and an accepted pop on a non-empty FIFO in the same cycle leave its fill level unchanged. A full receive FIFO accepts the push without overrun. A pop from an empty FIFO is ignored and the read data keeps its last value.
- R12: Each FIFO returns accepted words in the order they were pushed. Read data updates in the cycle after the pop strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable |
| frame_active | input | 1 | Shifter is moving a frame |
| rx_mask_en | input | 1 | Receive interrupt enable |
| tx_mask_en | input | 1 | Transmit interrupt enable |
| cpu_wr | input | 1 | Status register write strobe |
| cpu_wdata | input | 16 | Status register write data |
| cpu_rdata | output | 16 | Status register read value |
| cpu_tx_push | input | 1 | Write a word into the transmit FIFO |
| cpu_tx_data | input | 16 | Word to transmit |
| cpu_rx_pop | input | 1 | Read a word from the receive FIFO |
| cpu_rx_data | output | 16 | Last word read from the receive FIFO |
| sh_tx_pop | input | 1 | Shifter takes a transmit word |
| sh_tx_data | output | 16 | Last word taken from the transmit FIFO |
| sh_rx_push | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | 16 | Received word |
| busy | output | 1 | Busy indication |
| tx_irq | output | 1 | Masked transmit interrupt |
| rx_irq | output | 1 | Masked receive interrupt |
| ovr_irq | output | 1 | Unmaskable overrun interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The hardest state to reach is a receive FIFO sitting at its full level while the shifter keeps pushing. In that state an overrun must drop exactly the extra words, and a push paired with a pop must not count as an overrun. The stimulus fills the FIFO to eight words and sends two more distinct words. The scoreboard queue keeps only the words the model accepted, so draining the FIFO afterwards shows that the dropped words never entered it. A second fill to eight, followed by a push paired with a pop, checks the no-overrun case at the same boundary.

// File: rtl/serport_pkg.sv
package serport_pkg;
   localparam int unsigned ST_TNF = 1;
   localparam int unsigned ST_RNE = 2;
   localparam int unsigned ST_BSY = 3;
   localparam int unsigned ST_TSR = 4;
   localparam int unsigned ST_RSR = 5;
   localparam int unsigned ST_OVR = 6;
   localparam int unsigned ST_USED = 7;

   typedef enum logic {
      LVL_AT_MOST  = 1'b0,
      LVL_AT_LEAST = 1'b1
   } lvl_sense_e;
endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty,
   output logic              drop
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("serport_fifo: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("serport_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr_q, rptr_q;
   logic [CNT_W-1:0]  count_q;
   logic [DATA_W-1:0] rd_q;
   logic              pop_ok, accept;

   assign full   = (count_q == CNT_W'(DEPTH));
   assign empty  = (count_q == '0);
   assign pop_ok = pop && !empty && !flush;
   assign accept = push && !flush && (!full || pop_ok);
   assign drop   = push && !flush && full && !pop_ok;

   always_ff @(posedge clk) begin
      if (accept) mem[wptr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
         rd_q    <= '0;
      end else if (flush) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else begin
         if (accept) wptr_q <= wptr_q + 1'b1;
         if (pop_ok) begin
            rptr_q <= rptr_q + 1'b1;
            rd_q   <= mem[rptr_q];
         end
         case ({accept, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign pop_data = rd_q;
   assign count    = count_q;

   a_r11_pushpop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pop_ok) |=> $stable(count_q));
   a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> $stable(rd_q));
   a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0));
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/serport_svc.sv
module serport_svc
   import serport_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned THRESH = 4,
   parameter lvl_sense_e  SENSE  = LVL_AT_LEAST
) (
   input  logic [CNT_W-1:0] count,
   input  logic             en,
   input  logic             mask_en,
   output logic             svc,
   output logic             irq,
   output logic             dma
);
   generate
      if (THRESH >= (1 << CNT_W)) begin : g_bad_thresh
         $error("serport_svc: THRESH does not fit the count width");
      end
   endgenerate

   logic hit;

   generate
      if (SENSE == LVL_AT_LEAST) begin : g_fill
         assign hit = (count >= CNT_W'(THRESH));
      end else begin : g_room
         assign hit = (count <= CNT_W'(THRESH));
      end
   endgenerate

   assign svc = en && hit;
   assign dma = svc;
   assign irq = svc && mask_en;
endmodule

// File: rtl/serport_fifo_stat.sv
module serport_fifo_stat
   import serport_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned STAT_W    = 16,
   parameter int unsigned RX_THRESH = DEPTH / 2,
   parameter int unsigned TX_THRESH = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              frame_active,
   input  logic              rx_mask_en,
   input  logic              tx_mask_en,
   input  logic              cpu_wr,
   input  logic [STAT_W-1:0] cpu_wdata,
   output logic [STAT_W-1:0] cpu_rdata,
   input  logic              cpu_tx_push,
   input  logic [DATA_W-1:0] cpu_tx_data,
   input  logic              cpu_rx_pop,
   output logic [DATA_W-1:0] cpu_rx_data,
   input  logic              sh_tx_pop,
   output logic [DATA_W-1:0] sh_tx_data,
   input  logic              sh_rx_push,
   input  logic [DATA_W-1:0] sh_rx_data,
   output logic              busy,
   output logic              tx_irq,
   output logic              rx_irq,
   output logic              ovr_irq,
   output logic              tx_dma_req,
   output logic              rx_dma_req
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (STAT_W < ST_USED) begin : g_bad_stat
         $error("serport_fifo_stat: STAT_W too narrow for the status fields");
      end
      if (RX_THRESH < 1 || RX_THRESH > DEPTH || TX_THRESH >= DEPTH) begin : g_bad_lvl
         $error("serport_fifo_stat: thresholds out of range");
      end
   endgenerate

   logic             en_q, flush;
   logic             ovr_q;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             tx_full, tx_empty, tx_drop;
   logic             rx_full, rx_empty, rx_drop;
   logic             tx_svc, rx_svc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= port_en;
   end
   assign flush = en_q && !port_en;

   serport_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(cpu_tx_push), .push_data(cpu_tx_data),
      .pop(sh_tx_pop), .pop_data(sh_tx_data),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty), .drop(tx_drop)
   );

   serport_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(sh_rx_push), .push_data(sh_rx_data),
      .pop(cpu_rx_pop), .pop_data(cpu_rx_data),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty), .drop(rx_drop)
   );

   serport_svc #(.CNT_W(CNT_W), .THRESH(TX_THRESH), .SENSE(LVL_AT_MOST)) i_tx_svc (
      .count(tx_cnt), .en(port_en), .mask_en(tx_mask_en),
      .svc(tx_svc), .irq(tx_irq), .dma(tx_dma_req)
   );

   serport_svc #(.CNT_W(CNT_W), .THRESH(RX_THRESH), .SENSE(LVL_AT_LEAST)) i_rx_svc (
      .count(rx_cnt), .en(port_en), .mask_en(rx_mask_en),
      .svc(rx_svc), .irq(rx_irq), .dma(rx_dma_req)
   );

   // Overrun flag: a drop sets it, a write of 1 to its bit clears it, a drop wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ovr_q <= 1'b0;
      else if (rx_drop)                ovr_q <= 1'b1;
      else if (cpu_wr && cpu_wdata[ST_OVR]) ovr_q <= 1'b0;
   end

   assign busy    = port_en && frame_active;
   assign ovr_irq = ovr_q;

   always_comb begin
      cpu_rdata         = '0;
      cpu_rdata[ST_TNF] = !tx_full;
      cpu_rdata[ST_RNE] = !rx_empty;
      cpu_rdata[ST_BSY] = busy;
      cpu_rdata[ST_TSR] = tx_svc;
      cpu_rdata[ST_RSR] = rx_svc;
      cpu_rdata[ST_OVR] = ovr_q;
   end

   a_r4_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |=> ovr_irq);
   a_r5_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_irq) |-> $past(rx_drop));
   a_r8_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_wdata[ST_OVR] && !rx_drop) |=> !ovr_irq);
   a_r3_irq_implies_dma: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq |-> rx_dma_req) and (tx_irq |-> tx_dma_req));
   a_r7_busy_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> !busy);
endmodule

// File: tb/test_serport_fifo_stat.sv
module test_serport_fifo_stat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 0, frame_active = 0, rx_mask_en = 0, tx_mask_en = 0;
   logic        cpu_wr = 0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        cpu_tx_push = 0;
   logic [15:0] cpu_tx_data = '0;
   logic        cpu_rx_pop = 0;
   logic [15:0] cpu_rx_data;
   logic        sh_tx_pop = 0;
   logic [15:0] sh_tx_data;
   logic        sh_rx_push = 0;
   logic [15:0] sh_rx_data = '0;
   logic        busy, tx_irq, rx_irq, ovr_irq, tx_dma_req, rx_dma_req;

   int checks = 0;
   int failures = 0;
   logic [15:0] txq[$];
   logic [15:0] rxq[$];
   logic [15:0] tx_exp, rx_exp;
   bit          tx_pend = 0, rx_pend = 0;

   always #2 clk = ~clk;

   serport_fifo_stat i_serport_fifo_stat (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .frame_active(frame_active),
      .rx_mask_en(rx_mask_en), .tx_mask_en(tx_mask_en),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_tx_push(cpu_tx_push), .cpu_tx_data(cpu_tx_data),
      .cpu_rx_pop(cpu_rx_pop), .cpu_rx_data(cpu_rx_data),
      .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
      .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
      .busy(busy), .tx_irq(tx_irq), .rx_irq(rx_irq), .ovr_irq(ovr_irq),
      .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // Monitor: compares popped words one step after the popping edge.
   always @(posedge clk) begin
      #1;
      if (tx_pend) begin tx_pend = 0; chk("R12 tx order", sh_tx_data, tx_exp); end
      if (rx_pend) begin rx_pend = 0; chk("R12 rx order", cpu_rx_data, rx_exp); end
   end

   task automatic tx_push(input logic [15:0] d);
      cpu_tx_push = 1; cpu_tx_data = d;
      if (txq.size() < 8) txq.push_back(d);
      @(negedge clk);
      cpu_tx_push = 0;
   endtask

   task automatic tx_pop();
      sh_tx_pop = 1;
      if (txq.size() > 0) begin tx_exp = txq.pop_front(); tx_pend = 1; end
      @(negedge clk);
      sh_tx_pop = 0;
   endtask

   task automatic rx_cyc(input bit push, input logic [15:0] d, input bit pop);
      int sz;
      bit vp;
      sz = rxq.size();
      vp = pop && (sz > 0);
      sh_rx_push = push; sh_rx_data = d; cpu_rx_pop = pop;
      if (vp) begin rx_exp = rxq.pop_front(); rx_pend = 1; end
      if (push && (sz < 8 || vp)) rxq.push_back(d);
      @(negedge clk);
      sh_rx_push = 0; cpu_rx_pop = 0;
   endtask

   task automatic reg_wr(input logic [15:0] d);
      cpu_wr = 1; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] saved;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state
      chk("R9 status after reset", cpu_rdata, 16'h0002);
      chk("R9 ovr_irq after reset", {15'd0, ovr_irq}, 16'd0);
      chk("R2 tx_dma while disabled", {15'd0, tx_dma_req}, 16'd0);

      port_en = 1;
      @(negedge clk);
      chk("R6 R2 status enabled empty", cpu_rdata, 16'h0012);
      chk("R3 tx_dma unmasked", {14'd0, tx_dma_req, tx_irq}, 16'h0002);
      tx_mask_en = 1;
      @(negedge clk);
      chk("R3 tx_irq masked on", {15'd0, tx_irq}, 16'd1);

      for (int i = 0; i < 4; i++) tx_push(16'h1100 + 16'(i));
      chk("R2 tx request at 4", {15'd0, tx_dma_req}, 16'd1);
      tx_push(16'h1104);
      chk("R2 tx request at 5", {15'd0, tx_dma_req}, 16'd0);
      for (int i = 5; i < 8; i++) tx_push(16'h1100 + 16'(i));
      chk("R6 status tx full", cpu_rdata, 16'h0000);
      tx_mask_en = 0;
      for (int i = 0; i < 8; i++) tx_pop();
      @(negedge clk);
      saved = sh_tx_data;
      tx_pop();
      @(negedge clk);
      chk("R11 tx empty pop keeps data", sh_tx_data, saved);

      // receive thresholds
      for (int i = 0; i < 3; i++) rx_cyc(1, 16'h2200 + 16'(i), 0);
      chk("R1 rx request at 3", cpu_rdata, 16'h0016);
      rx_cyc(1, 16'h2203, 0);
      chk("R1 rx request at 4", cpu_rdata, 16'h0036);
      chk("R3 rx dma unmasked", {14'd0, rx_dma_req, rx_irq}, 16'h0002);
      rx_mask_en = 1;
      @(negedge clk);
      chk("R3 rx irq masked on", {15'd0, rx_irq}, 16'd1);
      rx_cyc(0, 16'h0, 1);
      chk("R1 rx request drops at 3", {15'd0, rx_dma_req}, 16'd0);

      // R11 push+pop at level 3 keeps level
      rx_cyc(1, 16'h2300, 1);
      chk("R11 push+pop level held", {15'd0, rx_dma_req}, 16'd0);
      rx_cyc(1, 16'h2301, 0);
      chk("R11 level reaches 4", {15'd0, rx_dma_req}, 16'd1);

      // fill to 8, then overrun twice
      rx_mask_en = 0;
      for (int i = 0; i < 4; i++) rx_cyc(1, 16'h2400 + 16'(i), 0);
      chk("R4 no overrun at full", {15'd0, ovr_irq}, 16'd0);
      rx_cyc(1, 16'hDEAD, 0);
      rx_cyc(1, 16'hBEEF, 0);
      chk("R4 overrun bit set", cpu_rdata, 16'h0076);
      chk("R5 ovr_irq with masks off", {15'd0, ovr_irq}, 16'd1);
      saved = cpu_rdata;
      reg_wr(16'hFFBF);
      chk("R8 write without bit6", cpu_rdata, saved);
      reg_wr(16'h0040);
      chk("R8 write one clears", cpu_rdata, 16'h0036);
      for (int i = 0; i < 8; i++) rx_cyc(0, 16'h0, 1);
      @(negedge clk);
      chk("R6 rx drained", cpu_rdata, 16'h0012);

      // R11 full with push+pop: no overrun
      for (int i = 0; i < 8; i++) rx_cyc(1, 16'h2500 + 16'(i), 0);
      rx_cyc(1, 16'h2508, 1);
      chk("R11 full push+pop no overrun", {15'd0, ovr_irq}, 16'd0);
      for (int i = 0; i < 8; i++) rx_cyc(0, 16'h0, 1);
      @(negedge clk);
      saved = cpu_rx_data;
      rx_cyc(0, 16'h0, 1);
      chk("R11 rx empty pop keeps data", cpu_rx_data, saved);

      // R7 busy
      frame_active = 1;
      @(negedge clk);
      chk("R7 busy enabled", cpu_rdata, 16'h001A);
      chk("R7 no irq from busy", {13'd0, tx_irq, rx_irq, ovr_irq}, 16'd0);

      // R10 flush on disable
      for (int i = 0; i < 3; i++) tx_push(16'h3300 + 16'(i));
      for (int i = 0; i < 5; i++) rx_cyc(1, 16'h3400 + 16'(i), 0);
      chk("R10 before disable", cpu_rdata, 16'h003E);
      port_en = 0;
      @(negedge clk);
      txq.delete();
      rxq.delete();
      chk("R10 R7 status after disable", cpu_rdata, 16'h0002);
      chk("R2 R1 dma off disabled", {14'd0, tx_dma_req, rx_dma_req}, 16'd0);
      frame_active = 0;
      port_en = 1;
      @(negedge clk);
      chk("R10 fifos empty after reenable", cpu_rdata, 16'h0012);

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end
endmodule